// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical address using a single-level page table that it holds itself. Every request gives a virtual address, an access kind (read, write or execute) and a privilege bit (user or supervisor). One cycle later the block answers with the physical address or with one of two fault flags. The low offset bits of the address pass straight through. The page number selects a table entry, and the entry's frame number is placed directly above the offset. No adder and no limit comparison are involved.

When an access succeeds, the block also records in the entry that was used that the page has been touched, and that it has been modified if the access was a write. Software fills the table through a write port, one entry per cycle. A combinational read port shows an entry's frame and status bits. If a software write and a status update hit the same entry in the same cycle, the software write wins.

Top module: `paged_xlate`

## Requirements
- R1: A request that does not fault returns, one cycle later, rspPaddr = {frame, vaddr[11:0]}. The page offset is the low 12 bits of the virtual address (4 KiB pages), and the page number is vaddr[31:12].
- R2: A page number equal to or greater than the table depth (default 16) returns rspPageFault=1.
- R3: A page number inside the table whose entry has present=0 returns rspPageFault=1.
- R4: A write access (reqAccess=2'b01) to an entry whose writable bit is 0 returns rspProtFault=1.
- R5: An execute access (reqAccess=2'b10) to an entry whose no-execute bit is 1 returns rspProtFault=1. Codes 2'b00 and 2'b11 are reads.
- R6: A user access (reqUser=1) to an entry whose user bit is 0 returns rspProtFault=1. A supervisor access (reqUser=0) is never refused for that reason.
- R7: A page fault takes priority over a protection fault, so the two flags are never both set. When either flag is set, rspPaddr is 0.
- R8: A request that does not fault sets the entry's accessed bit. A write that does not fault also sets its dirty bit. A read or execute leaves the dirty bit as it was.
- R9: A request that faults leaves the accessed and dirty bits of every entry unchanged.
- R10: A table write loads the frame and the permission bits and clears accessed and dirty. If it targets the entry that a request is using in the same cycle, the software values remain and the status update is dropped. The response of that request still reflects the entry as it was before the write.
- R11: After reset, rspValid, the fault flags and rspPaddr are 0, and every entry reads as not present with accessed and dirty cleared.
- R12: rspValid is 1 exactly in the cycle after a cycle in which reqValid was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspPaddr | output | 32 | Physical address, or 0 on a fault |
| rspPageFault | output | 1 | Out of range or page not present |
| rspProtFault | output | 1 | Permission violation |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | 4 | Entry index to write |
| tblWrFrame | input | 20 | Frame number to store |
| tblWrPresent | input | 1 | Present bit to store |
| tblWrWritable | input | 1 | Writable bit to store |
| tblWrUser | input | 1 | User-accessible bit to store |
| tblWrNoExec | input | 1 | No-execute bit to store |
| tblRdIdx | input | 4 | Entry index to observe |
| tblRdFrame | output | 20 | Frame number of the observed entry |
| tblRdAccessed | output | 1 | Accessed bit of the observed entry |
| tblRdDirty | output | 1 | Dirty bit of the observed entry |

## Verification
A software table write and the status-bit update of a successful lookup can both target the same entry on the same clock edge. The bench provokes this by raising tblWrEn with tblWrIdx equal to the page index of a request in the same cycle, sometimes with a write access so that the dirty bit would otherwise be set. It then reads the entry back through the read port. The check passes only if the entry holds the new frame with accessed and dirty cleared, while the response still carries the old frame or the old fault.

// File: rtl/pxlate_pkg.sv
package pxlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_t;

  // permission bits supplied by software
  typedef struct packed {
    logic present;
    logic writable;
    logic userOk;
    logic noExec;
  } pagePerm_t;

  // status bits maintained by the hardware
  typedef struct packed {
    logic accessed;
    logic dirty;
  } pageStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rspLoad;
    logic pageFault;
    logic protFault;
    logic setAccessed;
    logic setDirty;
  } xlateStrobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import pxlate_pkg::*;
#(
  parameter int PN_W  = 20,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             reqValid,
  input  logic [PN_W-1:0]  pageNum,
  input  logic [1:0]       reqAccess,
  input  logic             reqUser,
  input  pagePerm_t        lkPerm,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrIdx,
  output xlateStrobe_t     strobe
);

  logic inRange;
  logic isWrite;
  logic isExec;
  logic pgFault;
  logic prFault;
  logic collide;
  logic [IDX_W-1:0] lkIdx;

  assign lkIdx   = pageNum[IDX_W-1:0];
  assign inRange = (pageNum < PN_W'(DEPTH));
  assign isWrite = (accKind_t'(reqAccess) == ACC_WRITE);
  assign isExec  = (accKind_t'(reqAccess) == ACC_EXEC);

  always_comb begin
    pgFault = !inRange || !lkPerm.present;
    prFault = 1'b0;
    if (!pgFault) begin
      if (isWrite && !lkPerm.writable) prFault = 1'b1;
      if (isExec && lkPerm.noExec)     prFault = 1'b1;
      if (reqUser && !lkPerm.userOk)   prFault = 1'b1;
    end
  end

  // software write to the same entry wins over the status update
  assign collide = tblWrEn && (tblWrIdx == lkIdx);

  always_comb begin
    strobe             = '0;
    strobe.rspLoad     = reqValid;
    strobe.pageFault   = reqValid && pgFault;
    strobe.protFault   = reqValid && prFault;
    strobe.setAccessed = reqValid && !pgFault && !prFault && !collide;
    strobe.setDirty    = reqValid && !pgFault && !prFault && !collide && isWrite;
  end

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import pxlate_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int IDX_W   = 4,
  parameter int FRAME_W = 20,
  parameter int OFF_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlateStrobe_t       strobe,
  input  logic [IDX_W-1:0]   lkIdx,
  input  logic [OFF_W-1:0]   pageOff,
  output pagePerm_t          lkPerm,
  input  logic               tblWrEn,
  input  logic [IDX_W-1:0]   tblWrIdx,
  input  logic [FRAME_W-1:0] tblWrFrame,
  input  pagePerm_t          tblWrPerm,
  input  logic [IDX_W-1:0]   tblRdIdx,
  output logic [FRAME_W-1:0] tblRdFrame,
  output pageStat_t          tblRdStat,
  output logic               rspValid,
  output logic [FRAME_W+OFF_W-1:0] rspPaddr,
  output logic               rspPageFault,
  output logic               rspProtFault
);

  localparam int PA_W = FRAME_W + OFF_W;

  logic [FRAME_W-1:0] frameArr [DEPTH];
  pagePerm_t          permArr  [DEPTH];
  pageStat_t          statArr  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [FRAME_W-1:0] frameQ;
    pagePerm_t          permQ;
    pageStat_t          statQ;
    logic               wrHit;
    logic               updHit;

    assign wrHit  = tblWrEn && (tblWrIdx == IDX_W'(g));
    assign updHit = strobe.setAccessed && (lkIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        frameQ <= '0;
        permQ  <= '0;
        statQ  <= '0;
      end else if (wrHit) begin
        frameQ <= tblWrFrame;
        permQ  <= tblWrPerm;
        statQ  <= '0;
      end else if (updHit) begin
        statQ.accessed <= 1'b1;
        if (strobe.setDirty) statQ.dirty <= 1'b1;
      end
    end

    assign frameArr[g] = frameQ;
    assign permArr[g]  = permQ;
    assign statArr[g]  = statQ;
  end

  assign lkPerm     = permArr[lkIdx];
  assign tblRdFrame = frameArr[tblRdIdx];
  assign tblRdStat  = statArr[tblRdIdx];

  // concatenation only: frame sits above the untouched offset
  logic [PA_W-1:0] paddrNext;
  assign paddrNext = (strobe.pageFault || strobe.protFault) ? '0
                   : {frameArr[lkIdx], pageOff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspPaddr     <= '0;
      rspPageFault <= 1'b0;
      rspProtFault <= 1'b0;
    end else begin
      rspValid     <= strobe.rspLoad;
      rspPaddr     <= strobe.rspLoad ? paddrNext : '0;
      rspPageFault <= strobe.pageFault;
      rspProtFault <= strobe.protFault;
    end
  end

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
  import pxlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 20,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PN_W   = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  output logic               rspValid,
  output logic [PA_W-1:0]    rspPaddr,
  output logic               rspPageFault,
  output logic               rspProtFault,
  input  logic               tblWrEn,
  input  logic [IDX_W-1:0]   tblWrIdx,
  input  logic [FRAME_W-1:0] tblWrFrame,
  input  logic               tblWrPresent,
  input  logic               tblWrWritable,
  input  logic               tblWrUser,
  input  logic               tblWrNoExec,
  input  logic [IDX_W-1:0]   tblRdIdx,
  output logic [FRAME_W-1:0] tblRdFrame,
  output logic               tblRdAccessed,
  output logic               tblRdDirty
);

  logic [PN_W-1:0]  pageNum;
  logic [OFF_W-1:0] pageOff;
  logic [IDX_W-1:0] lkIdx;
  pagePerm_t        lkPerm;
  pagePerm_t        wrPerm;
  pageStat_t        rdStat;
  xlateStrobe_t     strobe;

  assign pageNum = reqVaddr[VA_W-1:OFF_W];
  assign pageOff = reqVaddr[OFF_W-1:0];
  assign lkIdx   = pageNum[IDX_W-1:0];

  assign wrPerm = '{present: tblWrPresent, writable: tblWrWritable,
                    userOk: tblWrUser, noExec: tblWrNoExec};

  xlate_ctrl #(.PN_W(PN_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .reqValid (reqValid),
    .pageNum  (pageNum),
    .reqAccess(reqAccess),
    .reqUser  (reqUser),
    .lkPerm   (lkPerm),
    .tblWrEn  (tblWrEn),
    .tblWrIdx (tblWrIdx),
    .strobe   (strobe)
  );

  xlate_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FRAME_W(FRAME_W),
                   .OFF_W(OFF_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lkIdx       (lkIdx),
    .pageOff     (pageOff),
    .lkPerm      (lkPerm),
    .tblWrEn     (tblWrEn),
    .tblWrIdx    (tblWrIdx),
    .tblWrFrame  (tblWrFrame),
    .tblWrPerm   (wrPerm),
    .tblRdIdx    (tblRdIdx),
    .tblRdFrame  (tblRdFrame),
    .tblRdStat   (rdStat),
    .rspValid    (rspValid),
    .rspPaddr    (rspPaddr),
    .rspPageFault(rspPageFault),
    .rspProtFault(rspProtFault)
  );

  assign tblRdAccessed = rdStat.accessed;
  assign tblRdDirty    = rdStat.dirty;

endmodule

// File: rtl/paged_xlate_checks.sv
module paged_xlate_checks #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int DEPTH = 16,
  parameter int PA_W  = 32,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [VA_W-1:0]  reqVaddr,
  input logic             rspValid,
  input logic [PA_W-1:0]  rspPaddr,
  input logic             rspPageFault,
  input logic             rspProtFault,
  input logic             tblWrEn,
  input logic [IDX_W-1:0] tblRdIdx,
  input logic             tblRdAccessed
);

  p_fault_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(rspPageFault && rspProtFault));

  p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspPageFault || rspProtFault) |-> (rspPaddr == '0));

  p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_range_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqVaddr[VA_W-1:OFF_W] >= (VA_W-OFF_W)'(DEPTH))) |=> rspPageFault);

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspPageFault || rspProtFault ||
                  rspPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])));

  p_idle_status_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !tblWrEn) |=>
      ((tblRdIdx != $past(tblRdIdx)) || (tblRdAccessed == $past(tblRdAccessed))));

endmodule

bind paged_xlate paged_xlate_checks #(
  .VA_W(VA_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .PA_W(PA_W), .IDX_W(IDX_W)
) u_checks (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqVaddr     (reqVaddr),
  .rspValid     (rspValid),
  .rspPaddr     (rspPaddr),
  .rspPageFault (rspPageFault),
  .rspProtFault (rspProtFault),
  .tblWrEn      (tblWrEn),
  .tblRdIdx     (tblRdIdx),
  .tblRdAccessed(tblRdAccessed)
);

// File: tb/paged_xlate_bench.sv
`timescale 1ns/1ps
module paged_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspPageFault;
  logic        rspProtFault;
  logic        tblWrEn = 1'b0;
  logic [3:0]  tblWrIdx = '0;
  logic [19:0] tblWrFrame = '0;
  logic        tblWrPresent = 1'b0;
  logic        tblWrWritable = 1'b0;
  logic        tblWrUser = 1'b0;
  logic        tblWrNoExec = 1'b0;
  logic [3:0]  tblRdIdx = '0;
  logic [19:0] tblRdFrame;
  logic        tblRdAccessed;
  logic        tblRdDirty;

  always #5 clk = ~clk;

  paged_xlate u_paged_xlate (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model of the table
  logic [19:0] mFrame [16];
  logic        mPres  [16];
  logic        mWr    [16];
  logic        mUsr   [16];
  logic        mNx    [16];
  logic        mAcc   [16];
  logic        mDty   [16];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic swWrite(input logic [3:0] idx, input logic [19:0] fr,
                         input logic p, input logic w, input logic u, input logic nx);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = idx; tblWrFrame = fr;
    tblWrPresent = p; tblWrWritable = w; tblWrUser = u; tblWrNoExec = nx;
    @(negedge clk);
    tblWrEn = 1'b0;
    mFrame[idx] = fr; mPres[idx] = p; mWr[idx] = w; mUsr[idx] = u; mNx[idx] = nx;
    mAcc[idx] = 1'b0; mDty[idx] = 1'b0;
  endtask

  task automatic checkEntry(input logic [3:0] idx, input string tag);
    tblRdIdx = idx;
    #1;
    chk({tag, " accessed"}, 64'(tblRdAccessed), 64'(mAcc[idx]));
    chk({tag, " dirty"}, 64'(tblRdDirty), 64'(mDty[idx]));
    chk({tag, " frame"}, 64'(tblRdFrame), 64'(mFrame[idx]));
  endtask

  // one request, optionally with a colliding software write to the same index
  task automatic request(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                         input bit col, input logic [19:0] cFr, input logic [3:0] cBits,
                         input string forceTag);
    logic [19:0] pn;
    logic [3:0]  idx;
    logic        expPf, expPr, inR;
    logic [31:0] expPa;
    string       tag;
    pn  = va[31:12];
    idx = va[15:12];
    inR = (pn < 20'd16);
    expPf = !inR || !mPres[idx];
    expPr = 1'b0;
    tag = "R1";
    if (!expPf) begin
      if (acc == 2'b01 && !mWr[idx]) begin expPr = 1'b1; tag = "R4"; end
      if (acc == 2'b10 && mNx[idx])  begin expPr = 1'b1; tag = "R5"; end
      if (usr && !mUsr[idx])         begin expPr = 1'b1; tag = "R6"; end
    end else tag = inR ? "R3" : "R2";
    if (forceTag != "") tag = forceTag;
    expPa = (expPf || expPr) ? 32'h0 : {mFrame[idx], va[11:0]};

    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc; reqUser = usr;
    if (col) begin
      tblWrEn = 1'b1; tblWrIdx = idx; tblWrFrame = cFr;
      tblWrPresent = cBits[3]; tblWrWritable = cBits[2];
      tblWrUser = cBits[1]; tblWrNoExec = cBits[0];
    end
    @(negedge clk);
    reqValid = 1'b0; tblWrEn = 1'b0;
    chk({tag, " R12 valid"}, 64'(rspValid), 64'd1);
    chk({tag, " pagefault"}, 64'(rspPageFault), 64'(expPf));
    chk({tag, " protfault"}, 64'(rspProtFault), 64'(expPr));
    chk({tag, " paddr"}, 64'(rspPaddr), 64'(expPa));

    if (col) begin
      mFrame[idx] = cFr; mPres[idx] = cBits[3]; mWr[idx] = cBits[2];
      mUsr[idx] = cBits[1]; mNx[idx] = cBits[0]; mAcc[idx] = 1'b0; mDty[idx] = 1'b0;
      checkEntry(idx, "R10");
    end else if (!expPf && !expPr) begin
      mAcc[idx] = 1'b1;
      if (acc == 2'b01) mDty[idx] = 1'b1;
      checkEntry(idx, "R8");
    end else if (inR) begin
      checkEntry(idx, "R9");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      mFrame[i] = '0; mPres[i] = 0; mWr[i] = 0; mUsr[i] = 0;
      mNx[i] = 0; mAcc[i] = 0; mDty[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 rspValid", 64'(rspValid), 64'd0);
    chk("R11 rspPaddr", 64'(rspPaddr), 64'd0);
    chk("R11 faults", 64'({rspPageFault, rspProtFault}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) checkEntry(4'(i), "R11");
    chk("R12 idle no rsp", 64'(rspValid), 64'd0);
    request(32'h0000_0ABC, 2'b00, 1'b0, 0, '0, '0, "R11");

    // directed cases
    swWrite(4'd1, 20'hABCDE, 1, 1, 1, 0);
    request(32'h0000_1123, 2'b00, 1'b1, 0, '0, '0, "R1");
    request(32'h0000_1FFF, 2'b01, 1'b1, 0, '0, '0, "R8");
    swWrite(4'd2, 20'h00777, 1, 0, 0, 1);
    request(32'h0000_2010, 2'b01, 1'b0, 0, '0, '0, "R4");
    request(32'h0000_2010, 2'b10, 1'b0, 0, '0, '0, "R5");
    request(32'h0000_2010, 2'b00, 1'b1, 0, '0, '0, "R6");
    request(32'h0000_2010, 2'b11, 1'b0, 0, '0, '0, "R6");
    request(32'h0001_0000, 2'b00, 1'b0, 0, '0, '0, "R2");
    request(32'hFFFF_F000, 2'b00, 1'b0, 0, '0, '0, "R2");
    swWrite(4'd3, 20'h12345, 0, 0, 0, 1);
    request(32'h0000_3004, 2'b01, 1'b1, 0, '0, '0, "R7");
    request(32'h0000_1000, 2'b01, 1'b0, 1, 20'h55555, 4'b1100, "R10");
    request(32'h0000_1000, 2'b00, 1'b0, 0, '0, '0, "R10");

    // constrained random mix
    for (int it = 0; it < 500; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25) begin
        swWrite(4'($urandom_range(0, 15)), 20'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
      end else begin
        logic [31:0] va;
        bit col;
        va = {12'h0, 8'($urandom_range(0, 19)), 12'($urandom)};
        col = (va[31:12] < 20'd16) && ($urandom_range(0, 9) == 0);
        request(va, 2'($urandom), 1'($urandom), col, 20'($urandom),
                4'($urandom), "");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule